// File: doc/BRIEF.md
# Physical Register Lifecycle Tracker

This block keeps the status of every physical register in a unified register file used by an out-of-order core with register renaming. Each register carries three status flags (free, architectural, ready) and sits in one of four states: free `{1,0,0}`, used and waiting for its result `{0,0,0}`, used with its result written but not yet committed `{0,0,1}`, and architectural `{0,1,1}`. The register values, the rename map and the reorder buffer are kept elsewhere. This block only holds the state flags.

The front end asks the block for a destination register and receives the lowest-numbered free one in the same cycle. Execution units report completion. The commit stage names the newly committed register and the register it replaces. A recovery pulse frees every register that was only used speculatively. Two combinational source ports tell the scheduler whether an operand's register already holds a usable value. The block accepts at most one event of each kind per cycle, and every event takes effect at the next rising clock edge.

Top module: `prt_status_tracker`

## Requirements
- R1: After reset, registers 0 to NUM_ARCH-1 are architectural (ready) and all other registers are free (not ready). `any_free` is 1 and the offered register `alloc_preg` equals NUM_ARCH.
- R2: `alloc_preg` always shows the lowest-numbered free register. When `alloc_req` is granted, that register becomes used and not ready from the next cycle, and the next free register is offered.
- R3: When `alloc_req` is high and no register is free, `alloc_stall` is 1, `alloc_grant` is 0 and no state changes.
- R4: A completion naming a used, not-ready register makes it ready from the next cycle.
- R5: An event that does not match the current state of the named register has no effect. For example, a completion naming a free register leaves it free and not ready. Every register always holds one of the four legal states.
- R6: A commit moves the new register from used-ready to architectural, where it stays ready. In the same cycle the commit moves the old register from architectural to free, so it reads not ready and can be allocated.
- R7: A recovery pulse makes every used register free from the next cycle. Architectural registers keep their state.
- R8: Recovery has priority over all other events in the same cycle. `alloc_grant` is 0 in that cycle and no register is allocated, completed or committed.
- R9: `src_a_rdy` and `src_b_rdy` are combinational and independent of each other. Each is 1 exactly when the queried register is used-ready or architectural.
- R10: `any_free` is 1 exactly when at least one register is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one destination register |
| alloc_grant | output | 1 | The request is served this cycle |
| alloc_preg | output | IW | Lowest free register (the one granted) |
| alloc_stall | output | 1 | Request made while no register is free |
| any_free | output | 1 | At least one register is free |
| cmpl_valid | input | 1 | A completion event is present |
| cmpl_preg | input | IW | Register whose result was written |
| cmt_valid | input | 1 | A commit event is present |
| cmt_new_preg | input | IW | Register becoming architectural |
| cmt_old_preg | input | IW | Register being released |
| recover | input | 1 | Free all used registers |
| src_a_preg | input | IW | First operand register query |
| src_a_rdy | output | 1 | First operand is available |
| src_b_preg | input | IW | Second operand register query |
| src_b_rdy | output | 1 | Second operand is available |

## Verification
The allocation outputs (`alloc_preg`, `alloc_grant`, `alloc_stall`), the source-ready outputs and `any_free` are combinational on the stored state and the current inputs. They are due in the same cycle as the stimulus. The effect of any event on stored state shows on the outputs one rising edge later. The bench drives inputs on the falling edge and checks same-cycle results a short delay later, before the next rising edge. It checks state effects only after the following falling edge, so exactly one register stage lies between each event and the check that observes it.

// File: rtl/prt_pkg.sv
package prt_pkg;
  // status flags of one physical register: {free, arch, ready}
  typedef struct packed {
    logic free;
    logic arch;
    logic rdy;
  } preg_st_t;

  localparam preg_st_t ST_FREE = preg_st_t'(3'b100);
  localparam preg_st_t ST_BUSY = preg_st_t'(3'b000);
  localparam preg_st_t ST_DONE = preg_st_t'(3'b001);
  localparam preg_st_t ST_ARCH = preg_st_t'(3'b011);

  // an operand may be read once its producer has written it
  function automatic logic operand_avail(preg_st_t s);
    return (s == ST_DONE) || (s == ST_ARCH);
  endfunction

  function automatic logic state_legal(preg_st_t s);
    return (s == ST_FREE) || (s == ST_BUSY) || (s == ST_DONE) || (s == ST_ARCH);
  endfunction
endpackage

// File: rtl/prt_pick.sv
module prt_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prt_entry.sv
module prt_entry
  import prt_pkg::*;
#(
  parameter bit INIT_ARCH = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     recover,
  input  logic     alloc_hit,
  input  logic     cmpl_hit,
  input  logic     promote_hit,
  input  logic     release_hit,
  output preg_st_t st
);
  preg_st_t st_nxt;

  always_comb begin
    st_nxt = st;
    if (recover) begin
      if (st != ST_ARCH) st_nxt = ST_FREE;
    end else if (alloc_hit && st == ST_FREE) begin
      st_nxt = ST_BUSY;
    end else if (cmpl_hit && st == ST_BUSY) begin
      st_nxt = ST_DONE;
    end else if (promote_hit && st == ST_DONE) begin
      st_nxt = ST_ARCH;
    end else if (release_hit && st == ST_ARCH) begin
      st_nxt = ST_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= INIT_ARCH ? ST_ARCH : ST_FREE;
    else        st <= st_nxt;
  end

  p_legal_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_legal(st));

  p_cmpl_on_free_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_hit && st == ST_FREE && !alloc_hit && !recover) |=> st == ST_FREE);

  p_recover_clears_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> (st == ST_FREE || st == ST_ARCH));

  p_recover_keeps_arch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (recover && st == ST_ARCH) |=> st == ST_ARCH);
endmodule

// File: rtl/prt_status_tracker.sv
module prt_status_tracker
  import prt_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int NUM_ARCH  = 32,
  localparam int IW       = $clog2(NUM_PREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic          alloc_grant,
  output logic [IW-1:0] alloc_preg,
  output logic          alloc_stall,
  output logic          any_free,
  input  logic          cmpl_valid,
  input  logic [IW-1:0] cmpl_preg,
  input  logic          cmt_valid,
  input  logic [IW-1:0] cmt_new_preg,
  input  logic [IW-1:0] cmt_old_preg,
  input  logic          recover,
  input  logic [IW-1:0] src_a_preg,
  output logic          src_a_rdy,
  input  logic [IW-1:0] src_b_preg,
  output logic          src_b_rdy
);
  preg_st_t             st_arr [NUM_PREGS];
  logic [NUM_PREGS-1:0] free_vec;
  logic [NUM_PREGS-1:0] busy_vec;
  logic [NUM_PREGS-1:0] done_vec;
  logic [NUM_PREGS-1:0] arch_vec;

  // named event wires
  logic alloc_fire;
  logic cmpl_fire;
  logic cmt_fire;

  prt_pick #(.N(NUM_PREGS), .IW(IW)) u_pick (
    .req_vec (free_vec),
    .idx     (alloc_preg),
    .found   (any_free)
  );

  assign alloc_fire  = alloc_req && any_free && !recover;
  assign cmpl_fire   = cmpl_valid && !recover;
  assign cmt_fire    = cmt_valid && !recover;
  assign alloc_grant = alloc_fire;
  assign alloc_stall = alloc_req && !any_free;

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_entry
    prt_entry #(.INIT_ARCH(g < NUM_ARCH)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .recover     (recover),
      .alloc_hit   (alloc_fire && alloc_preg == IW'(g)),
      .cmpl_hit    (cmpl_fire && cmpl_preg == IW'(g)),
      .promote_hit (cmt_fire && cmt_new_preg == IW'(g)),
      .release_hit (cmt_fire && cmt_old_preg == IW'(g)),
      .st          (st_arr[g])
    );
    assign free_vec[g] = (st_arr[g] == ST_FREE);
    assign busy_vec[g] = (st_arr[g] == ST_BUSY);
    assign done_vec[g] = (st_arr[g] == ST_DONE);
    assign arch_vec[g] = (st_arr[g] == ST_ARCH);
  end

  assign src_a_rdy = operand_avail(st_arr[src_a_preg]);
  assign src_b_rdy = operand_avail(st_arr[src_b_preg]);

  p_grant_makes_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> busy_vec[$past(alloc_preg)]);

  p_stall_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |-> !alloc_grant);

  p_commit_promotes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !recover && done_vec[cmt_new_preg]) |=> arch_vec[$past(cmt_new_preg)]);

  p_recover_drops_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> !alloc_grant);

  p_recover_no_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> (busy_vec == '0 && done_vec == '0));
endmodule

// File: tb/sim_prt_status_tracker.sv
module sim_prt_status_tracker;
  localparam int NP = 64;
  localparam int NA = 32;
  localparam int IW = 6;

  // field codes for scoreboard items
  localparam int F_PREG  = 0;
  localparam int F_GRANT = 1;
  localparam int F_STALL = 2;
  localparam int F_ANY   = 3;
  localparam int F_ARDY  = 4;
  localparam int F_BRDY  = 5;

  typedef struct {
    int    fld;
    int    exp;
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req = 1'b0;
  logic          alloc_grant;
  logic [IW-1:0] alloc_preg;
  logic          alloc_stall;
  logic          any_free;
  logic          cmpl_valid = 1'b0;
  logic [IW-1:0] cmpl_preg = '0;
  logic          cmt_valid = 1'b0;
  logic [IW-1:0] cmt_new_preg = '0;
  logic [IW-1:0] cmt_old_preg = '0;
  logic          recover = 1'b0;
  logic [IW-1:0] src_a_preg = '0;
  logic          src_a_rdy;
  logic [IW-1:0] src_b_preg = '0;
  logic          src_b_rdy;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  item_t sb_q[$];
  event  mon_ev;
  event  mon_done;

  always #4 clk = ~clk;

  prt_status_tracker #(.NUM_PREGS(NP), .NUM_ARCH(NA)) u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_grant(alloc_grant), .alloc_preg(alloc_preg),
    .alloc_stall(alloc_stall), .any_free(any_free),
    .cmpl_valid(cmpl_valid), .cmpl_preg(cmpl_preg),
    .cmt_valid(cmt_valid), .cmt_new_preg(cmt_new_preg), .cmt_old_preg(cmt_old_preg),
    .recover(recover),
    .src_a_preg(src_a_preg), .src_a_rdy(src_a_rdy),
    .src_b_preg(src_b_preg), .src_b_rdy(src_b_rdy)
  );

  function automatic int observe(int fld);
    case (fld)
      F_PREG:  return int'(alloc_preg);
      F_GRANT: return int'(alloc_grant);
      F_STALL: return int'(alloc_stall);
      F_ANY:   return int'(any_free);
      F_ARDY:  return int'(src_a_rdy);
      default: return int'(src_b_rdy);
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        int got;
        it  = sb_q.pop_front();
        got = observe(it.fld);
        total++;
        if (got != it.exp) begin
          bad++;
          $display("FAIL %s field=%0d actual=%0d expected=%0d", it.req, it.fld, got, it.exp);
        end
      end
      -> mon_done;
    end
  end

  task automatic expect_val(int fld, int exp, string req);
    item_t it;
    it.fld = fld; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  // start a cycle: idle all event inputs at the falling edge
  task automatic cyc_begin();
    @(negedge clk);
    alloc_req = 1'b0; cmpl_valid = 1'b0; cmt_valid = 1'b0; recover = 1'b0;
  endtask

  // evaluate queued expectations before the next rising edge
  task automatic check_now();
    #1;
    -> mon_ev;
    @(mon_done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc_begin();
    src_a_preg = 6'd0; src_b_preg = 6'd40;
    expect_val(F_ARDY, 1, "R1");
    expect_val(F_BRDY, 0, "R1");
    expect_val(F_ANY, 1, "R10");
    expect_val(F_PREG, NA, "R1");
    expect_val(F_STALL, 0, "R1");
    check_now();

    // R2 allocate 32
    cyc_begin();
    alloc_req = 1'b1;
    expect_val(F_GRANT, 1, "R2");
    expect_val(F_PREG, 32, "R2");
    check_now();

    // R2 next offers 33; 32 is now not ready
    cyc_begin();
    alloc_req = 1'b1; src_a_preg = 6'd32;
    expect_val(F_PREG, 33, "R2");
    expect_val(F_ARDY, 0, "R2");
    check_now();

    // R4 complete 32 ; R5 complete free register 40
    cyc_begin();
    cmpl_valid = 1'b1; cmpl_preg = 6'd32;
    check_now();
    cyc_begin();
    cmpl_valid = 1'b1; cmpl_preg = 6'd40;
    src_a_preg = 6'd32;
    expect_val(F_ARDY, 1, "R4");
    expect_val(F_PREG, 34, "R4");
    check_now();
    cyc_begin();
    src_b_preg = 6'd40;
    expect_val(F_BRDY, 0, "R5");
    expect_val(F_PREG, 34, "R5");
    check_now();

    // R6 commit new=32 old=5
    cyc_begin();
    cmt_valid = 1'b1; cmt_new_preg = 6'd32; cmt_old_preg = 6'd5;
    check_now();
    cyc_begin();
    src_a_preg = 6'd32; src_b_preg = 6'd5;
    expect_val(F_ARDY, 1, "R6");
    expect_val(F_BRDY, 0, "R6");
    expect_val(F_PREG, 5, "R6");
    check_now();

    // allocate 5 (busy), complete 33 (done)
    cyc_begin();
    alloc_req = 1'b1;
    expect_val(F_PREG, 5, "R2");
    check_now();
    cyc_begin();
    cmpl_valid = 1'b1; cmpl_preg = 6'd33;
    check_now();

    // R8 recovery with allocation and completion in the same cycle
    cyc_begin();
    recover = 1'b1; alloc_req = 1'b1; cmpl_valid = 1'b1; cmpl_preg = 6'd5;
    expect_val(F_GRANT, 0, "R8");
    check_now();

    // R7 used registers freed, architectural kept
    cyc_begin();
    src_a_preg = 6'd33; src_b_preg = 6'd32;
    expect_val(F_ARDY, 0, "R7");
    expect_val(F_BRDY, 1, "R7");
    expect_val(F_PREG, 5, "R7");
    check_now();
    cyc_begin();
    src_a_preg = 6'd5; src_b_preg = 6'd1;
    expect_val(F_ARDY, 0, "R8");
    expect_val(F_BRDY, 1, "R9");
    check_now();

    // exhaust the free pool: 5, then 33..63
    for (int i = 0; i < 32; i++) begin
      cyc_begin();
      alloc_req = 1'b1;
      expect_val(F_GRANT, 1, "R2");
      expect_val(F_PREG, (i == 0) ? 5 : 32 + i, "R2");
      check_now();
    end

    // R3 stall when empty, R10 any_free low
    cyc_begin();
    alloc_req = 1'b1;
    expect_val(F_ANY, 0, "R10");
    expect_val(F_STALL, 1, "R3");
    expect_val(F_GRANT, 0, "R3");
    check_now();

    // complete 40, commit 40 replacing 0
    cyc_begin();
    cmpl_valid = 1'b1; cmpl_preg = 6'd40;
    check_now();
    cyc_begin();
    cmt_valid = 1'b1; cmt_new_preg = 6'd40; cmt_old_preg = 6'd0;
    check_now();
    cyc_begin();
    src_a_preg = 6'd40; src_b_preg = 6'd0;
    expect_val(F_ANY, 1, "R10");
    expect_val(F_PREG, 0, "R6");
    expect_val(F_ARDY, 1, "R9");
    expect_val(F_BRDY, 0, "R9");
    expect_val(F_STALL, 0, "R3");
    check_now();

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule